// File: doc/BRIEF.md
# Interrupt Priority Arbiter with Instruction-Counted Lockout

This block decides which of a set of interrupt sources is offered to the CPU for service. Every source latches its request into a pending flag. Each source also has its own enable bit, a 4-bit priority level and a 2-bit group rank, and one global enable gates all sources together. Every cycle the block picks the best pending, enabled source. It offers that source to the CPU only when the source's level is strictly above the CPU's current priority level and no lockout window is running.

A lockout window masks every request for a programmed number of retired instructions, from 1 to 4. The CPU opens it when it executes an atomic or extend-type instruction, and each instruction-retire strobe counts one instruction down. Requests that arrive while the block is masked stay pending and are arbitrated once the mask clears.

The service offer is a valid/ready handshake. `svc_valid_o` offers the source `svc_idx_o` at level `svc_lvl_o`. A transfer happens on a clock edge where both `svc_valid_o` and `svc_ready_i` are high; that clears the source's pending flag, and the CPU may then adopt `svc_lvl_o` as its new level. Holding `svc_ready_i` low applies back-pressure, and every pending flag is kept. The offer is recomputed every cycle, so unlike a data stream it may change or be withdrawn before it is accepted. It changes when a better request arrives, the CPU level rises or a lockout starts. The CPU must sample index and level only on the accepting edge.

Top module: `irq_prio_arbiter`

## Requirements
- R1: A source is a candidate only while its `src_en_i` bit and `glob_en_i` are both high; otherwise it is never offered, and its pending flag is kept.
- R2: A candidate is offered only if its level is strictly greater than `cpu_lvl_i`. A CPU level equal to or above the source's level blocks it.
- R3: A source whose 4-bit level field is 0 is never offered, whatever its other settings.
- R4: Among the candidates, the highest level wins. At equal levels, the higher 2-bit group value wins. Any remaining tie goes to the lowest source index. Source i uses level bits `lvl_cfg_i[4i+3:4i]` and group bits `grp_cfg_i[2i+1:2i]`.
- R5: A cycle with `lock_start_i` high loads the lockout counter with `lock_len_i + 1`, so encodings 0 to 3 give 1 to 4 instructions. Each later cycle with `retire_i` high decrements a nonzero counter. A retire in the same cycle as the start does not count. No offer is made while the counter is nonzero.
- R6: A `lock_start_i` during an active window reloads the counter from the new `lock_len_i`.
- R7: A one-cycle pulse on `req_i[i]` sets pending flag i. The flag stays set, whether the source is masked, disabled or below the CPU level, until that source is accepted.
- R8: An accepting edge (`svc_valid_o` and `svc_ready_i` both high) clears the pending flag of `svc_idx_o`. If `req_i` for that same source is high in that cycle, the flag stays set. `svc_idx_o` and `svc_lvl_o` carry the offered source's index and level while `svc_valid_o` is high.
- R9: The outputs are registered. They reflect the inputs and pending flags as updated at the previous clock edge, one cycle after any input change.
- R10: During and immediately after reset, all pending flags are clear, the lockout counter is zero and `svc_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 16 | Request pulses, one per source |
| src_en_i | input | 16 | Per-source enable |
| glob_en_i | input | 1 | Global interrupt enable |
| lvl_cfg_i | input | 64 | Packed 4-bit priority levels, source 0 in the low bits |
| grp_cfg_i | input | 32 | Packed 2-bit group ranks, source 0 in the low bits |
| cpu_lvl_i | input | 4 | Current CPU priority level |
| lock_start_i | input | 1 | Opens or reloads a lockout window |
| lock_len_i | input | 2 | Window length minus one |
| retire_i | input | 1 | One instruction retired |
| svc_valid_o | output | 1 | Service offer valid |
| svc_ready_i | input | 1 | CPU accepts the offer |
| svc_idx_o | output | 4 | Offered source index |
| svc_lvl_o | output | 4 | Offered source level |

## Verification
Internal state goes wrong in three ways here, and each shows up at the service port within one cycle. A pending flag that is lost, or left set after its acceptance, shows up as a missing or repeated offer. A lockout count that is off by one lets an offer appear one retire too early, or keeps it away one retire too long. A wrong tie-break shows up as a different index on `svc_idx_o`. A behavioural model in the bench tracks pending flags and the window count. It compares the valid, index and level outputs every cycle, so any such fault is reported on the first cycle it changes the offer.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  // lockout window: 2-bit length code, 1 to 4 instructions
  localparam int LOCK_LEN_W = 2;
  localparam int LOCK_CNT_W = 3;

  typedef logic [LOCK_LEN_W-1:0] lock_len_t;
  typedef logic [LOCK_CNT_W-1:0] lock_cnt_t;

  localparam lock_cnt_t LOCK_MAX = lock_cnt_t'(1 << LOCK_LEN_W);

  function automatic lock_cnt_t lock_load(input lock_len_t len);
    return lock_cnt_t'(len) + lock_cnt_t'(1);
  endfunction

endpackage

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               clr_en_i,
  input  logic [IDX_W-1:0]   clr_idx_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] pend_next_o
);

  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] clr_mask;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
      assign clr_mask[i] = clr_en_i && (clr_idx_i == IDX_W'(i));
    end
  endgenerate

  // a fresh request beats the clear of the same source
  assign pend_next_o = (pend_q & ~clr_mask) | req_i;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_next_o;
  end

  assign pend_o = pend_q;

  // R8: accepted source drops unless re-requested in the same cycle
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en_i && !req_i[clr_idx_i]) |=> !pend_q[$past(clr_idx_i)]);

  // R7: no flag is lost except by acceptance
  assert_pend_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q & ~clr_mask) & ~pend_q) == '0));

endmodule

// File: rtl/irq_lockout_ctr.sv
module irq_lockout_ctr
  import irq_arb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  lock_len_t len_i,
  input  logic      retire_i,
  output lock_cnt_t cnt_o,
  output logic      locked_next_o
);

  lock_cnt_t cnt_q;
  lock_cnt_t cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)                          cnt_d = lock_load(len_i);
    else if (retire_i && cnt_q != '0)     cnt_d = cnt_q - lock_cnt_t'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o         = cnt_q;
  assign locked_next_o = (cnt_d != '0);

  // R5: window never exceeds four instructions
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOCK_MAX);

  // R6: a start always (re)loads from the new length
  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cnt_q == lock_cnt_t'($past(len_i)) + lock_cnt_t'(1)));

  // R5: a retire steps the window down by exactly one
  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && retire_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - lock_cnt_t'(1)));

endmodule

// File: rtl/irq_prio_tree.sv
module irq_prio_tree #(
  parameter int NUM_SRC = 16,
  parameter int LVL_W   = 4,
  parameter int GRP_W   = 2,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_SRC-1:0]       elig_i,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_flat_i,
  input  logic [NUM_SRC*GRP_W-1:0] grp_flat_i,
  output logic                     win_vld_o,
  output logic [IDX_W-1:0]         win_idx_o,
  output logic [LVL_W-1:0]         win_lvl_o
);

  localparam int KEY_W  = LVL_W + GRP_W;
  localparam int LEAVES = 1 << $clog2(NUM_SRC);
  localparam int NODES  = 2 * LEAVES - 1;
  localparam int FIRST  = LEAVES - 1;

  logic             n_vld [NODES];
  logic [KEY_W-1:0] n_key [NODES];
  logic [IDX_W-1:0] n_idx [NODES];

  // leaves in index order; left subtrees always hold lower indices
  generate
    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
      if (i < NUM_SRC) begin : g_real
        assign n_vld[FIRST+i] = elig_i[i];
        assign n_key[FIRST+i] = {lvl_flat_i[i*LVL_W +: LVL_W], grp_flat_i[i*GRP_W +: GRP_W]};
        assign n_idx[FIRST+i] = IDX_W'(i);
      end else begin : g_pad
        assign n_vld[FIRST+i] = 1'b0;
        assign n_key[FIRST+i] = '0;
        assign n_idx[FIRST+i] = '0;
      end
    end
    for (genvar k = 0; k < FIRST; k++) begin : g_node
      logic take_left;
      assign take_left = n_vld[2*k+1] &&
                         (!n_vld[2*k+2] || n_key[2*k+1] >= n_key[2*k+2]);
      assign n_vld[k] = n_vld[2*k+1] | n_vld[2*k+2];
      assign n_key[k] = take_left ? n_key[2*k+1] : n_key[2*k+2];
      assign n_idx[k] = take_left ? n_idx[2*k+1] : n_idx[2*k+2];
    end
  endgenerate

  assign win_vld_o = n_vld[0];
  assign win_idx_o = n_idx[0];
  assign win_lvl_o = n_key[0][KEY_W-1 -: LVL_W];

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int LVL_W   = 4,
  parameter int GRP_W   = 2,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       req_i,
  input  logic [NUM_SRC-1:0]       src_en_i,
  input  logic                     glob_en_i,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_cfg_i,
  input  logic [NUM_SRC*GRP_W-1:0] grp_cfg_i,
  input  logic [LVL_W-1:0]         cpu_lvl_i,
  input  logic                     lock_start_i,
  input  logic [LOCK_LEN_W-1:0]    lock_len_i,
  input  logic                     retire_i,
  output logic                     svc_valid_o,
  input  logic                     svc_ready_i,
  output logic [IDX_W-1:0]         svc_idx_o,
  output logic [LVL_W-1:0]         svc_lvl_o
);

  logic               svc_valid_q;
  logic [IDX_W-1:0]   svc_idx_q;
  logic [LVL_W-1:0]   svc_lvl_q;
  logic               accept;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] pend_next;
  logic [NUM_SRC-1:0] lvl_live;
  logic [NUM_SRC-1:0] elig;
  lock_cnt_t          lock_cnt;
  logic               locked_next;
  logic               win_vld;
  logic [IDX_W-1:0]   win_idx;
  logic [LVL_W-1:0]   win_lvl;
  logic               offer;

  assign accept = svc_valid_q & svc_ready_i;

  irq_pending_bank #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pend (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .clr_en_i    (accept),
    .clr_idx_i   (svc_idx_q),
    .pend_o      (pend_q),
    .pend_next_o (pend_next)
  );

  irq_lockout_ctr u_lock (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (lock_start_i),
    .len_i         (lock_len_i),
    .retire_i      (retire_i),
    .cnt_o         (lock_cnt),
    .locked_next_o (locked_next)
  );

  // level 0 parks a source permanently
  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_live
      assign lvl_live[i] = (lvl_cfg_i[i*LVL_W +: LVL_W] != '0);
    end
  endgenerate

  assign elig = pend_next & src_en_i & lvl_live & {NUM_SRC{glob_en_i}};

  irq_prio_tree #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .GRP_W(GRP_W), .IDX_W(IDX_W)) u_tree (
    .elig_i     (elig),
    .lvl_flat_i (lvl_cfg_i),
    .grp_flat_i (grp_cfg_i),
    .win_vld_o  (win_vld),
    .win_idx_o  (win_idx),
    .win_lvl_o  (win_lvl)
  );

  assign offer = win_vld && (win_lvl > cpu_lvl_i) && !locked_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      svc_valid_q <= 1'b0;
      svc_idx_q   <= '0;
      svc_lvl_q   <= '0;
    end else begin
      svc_valid_q <= offer;
      svc_idx_q   <= win_idx;
      svc_lvl_q   <= win_lvl;
    end
  end

  assign svc_valid_o = svc_valid_q;
  assign svc_idx_o   = svc_idx_q;
  assign svc_lvl_o   = svc_lvl_q;

  // R1: no offer after a cycle with global enable low
  assert_need_global_R1: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid_o |-> $past(glob_en_i));

  // R2: offered level beats the CPU level of the previous cycle
  assert_above_cpu_R2: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid_o |-> (svc_lvl_o > $past(cpu_lvl_i)));

  // R5: quiet while a window is open
  assert_lock_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_cnt != '0) |-> !svc_valid_o);

  // R8: an offer names a source that is still pending
  assert_offer_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid_o |-> pend_q[svc_idx_o]);

endmodule

// File: tb/irq_prio_arbiter_test.sv
module irq_prio_arbiter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req_i = '0;
  logic [15:0] src_en_i = '0;
  logic        glob_en_i = 1'b0;
  logic [63:0] lvl_cfg_i = '0;
  logic [31:0] grp_cfg_i = '0;
  logic [3:0]  cpu_lvl_i = '0;
  logic        lock_start_i = 1'b0;
  logic [1:0]  lock_len_i = '0;
  logic        retire_i = 1'b0;
  logic        svc_valid_o;
  logic        svc_ready_i = 1'b0;
  logic [3:0]  svc_idx_o;
  logic [3:0]  svc_lvl_o;

  irq_prio_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .src_en_i(src_en_i),
    .glob_en_i(glob_en_i), .lvl_cfg_i(lvl_cfg_i), .grp_cfg_i(grp_cfg_i),
    .cpu_lvl_i(cpu_lvl_i), .lock_start_i(lock_start_i), .lock_len_i(lock_len_i),
    .retire_i(retire_i), .svc_valid_o(svc_valid_o), .svc_ready_i(svc_ready_i),
    .svc_idx_o(svc_idx_o), .svc_lvl_o(svc_lvl_o)
  );

  always #5 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string tag = "R10";

  // reference model state
  bit m_pend [16];
  int m_cnt = 0;
  bit exp_v = 1'b0;
  int exp_i = 0;
  int exp_l = 0;

  function automatic int lvl_of(int i);
    return int'(lvl_cfg_i[i*4 +: 4]);
  endfunction

  function automatic int grp_of(int i);
    return int'(grp_cfg_i[i*2 +: 2]);
  endfunction

  task automatic check(bit ok, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic compare();
    check(svc_valid_o == exp_v, "valid", int'(svc_valid_o), int'(exp_v));
    if (exp_v && svc_valid_o) begin
      check(int'(svc_idx_o) == exp_i, "index", int'(svc_idx_o), exp_i);
      check(int'(svc_lvl_o) == exp_l, "level", int'(svc_lvl_o), exp_l);
    end
  endtask

  task automatic model_step();
    int best = -1;
    int bkey = -1;
    if (exp_v && svc_ready_i) m_pend[exp_i] = 1'b0;
    for (int i = 0; i < 16; i++) if (req_i[i]) m_pend[i] = 1'b1;
    if (lock_start_i) m_cnt = int'(lock_len_i) + 1;
    else if (retire_i && m_cnt > 0) m_cnt--;
    for (int i = 0; i < 16; i++) begin
      if (m_pend[i] && src_en_i[i] && glob_en_i && lvl_of(i) != 0) begin
        int k = lvl_of(i) * 4 + grp_of(i);
        if (k > bkey) begin
          bkey = k;
          best = i;
        end
      end
    end
    exp_v = (best >= 0) && (m_cnt == 0) && (lvl_of(best) > int'(cpu_lvl_i));
    exp_i = (best >= 0) ? best : 0;
    exp_l = (best >= 0) ? lvl_of(best) : 0;
  endtask

  // inputs are set after a falling edge; model follows the rising edge
  task automatic tick();
    model_step();
    @(negedge clk);
    compare();
    req_i = '0;
    lock_start_i = 1'b0;
  endtask

  task automatic idle(int n);
    for (int c = 0; c < n; c++) tick();
  endtask

  task automatic set_lvl(int i, int l, int g);
    lvl_cfg_i[i*4 +: 4] = 4'(l);
    grp_cfg_i[i*2 +: 2] = 2'(g);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_pend[i] = 1'b0;
    for (int i = 0; i < 16; i++) set_lvl(i, ((i * 7) % 15) + 1, i % 4);
    set_lvl(3, 0, 3);
    repeat (3) @(negedge clk);
    tag = "R10";
    compare();
    rst_n = 1'b1;
    idle(2);

    // R1: global enable low, then source enables low
    tag = "R1";
    src_en_i = '1;
    req_i = 16'hFFFF;
    tick();
    idle(3);
    glob_en_i = 1'b1;
    src_en_i = '0;
    idle(3);
    // R7: flags kept through the disabled stretch, drained in R4 order
    tag = "R7";
    src_en_i = '1;
    idle(2);
    tag = "R8";
    svc_ready_i = 1'b1;
    idle(20);

    // R3: level 0 source never offered
    tag = "R3";
    req_i = 16'h0008;
    idle(5);

    // R2: equal CPU level blocks, one lower lets through
    tag = "R2";
    svc_ready_i = 1'b0;
    set_lvl(5, 9, 0);
    cpu_lvl_i = 4'd9;
    req_i = 16'h0020;
    idle(3);
    cpu_lvl_i = 4'd10;
    idle(2);
    cpu_lvl_i = 4'd8;
    idle(2);
    svc_ready_i = 1'b1;
    idle(3);
    cpu_lvl_i = 4'd0;

    // R4: level, then group, then index
    tag = "R4";
    svc_ready_i = 1'b0;
    set_lvl(1, 12, 1);
    set_lvl(2, 12, 1);
    set_lvl(6, 12, 2);
    set_lvl(9, 11, 3);
    req_i = 16'h0246;
    idle(2);
    svc_ready_i = 1'b1;
    idle(6);

    // R8: re-request on the accepting cycle keeps the flag
    tag = "R8";
    svc_ready_i = 1'b0;
    req_i = 16'h0040;
    idle(2);
    svc_ready_i = 1'b1;
    req_i = 16'h0040;
    idle(4);

    // R5: window of three retires, requests held meanwhile
    tag = "R5";
    svc_ready_i = 1'b0;
    lock_start_i = 1'b1;
    lock_len_i = 2'd2;
    retire_i = 1'b1;
    req_i = 16'h0102;
    tick();
    retire_i = 1'b0;
    idle(2);
    for (int c = 0; c < 4; c++) begin
      retire_i = 1'b1;
      tick();
      retire_i = 1'b0;
      tick();
    end
    // R6: reload during an open window
    tag = "R6";
    lock_start_i = 1'b1;
    lock_len_i = 2'd3;
    tick();
    retire_i = 1'b1;
    idle(2);
    lock_start_i = 1'b1;
    lock_len_i = 2'd0;
    retire_i = 1'b0;
    tick();
    idle(2);
    retire_i = 1'b1;
    idle(2);
    retire_i = 1'b0;
    svc_ready_i = 1'b1;
    idle(6);

    // R9: CPU level and enables toggling every cycle
    tag = "R9";
    svc_ready_i = 1'b0;
    req_i = 16'hA5A5;
    for (int c = 0; c < 16; c++) begin
      cpu_lvl_i = 4'(c);
      glob_en_i = (c % 3) != 0;
      tick();
    end
    glob_en_i = 1'b1;

    // random traffic under the model (R4 ordering throughout)
    tag = "R4";
    for (int c = 0; c < 4000; c++) begin
      int r = $urandom_range(0, 99);
      req_i = (r < 30) ? 16'(1 << $urandom_range(0, 15)) : 16'h0;
      if (r < 3) req_i = 16'($urandom);
      src_en_i = ($urandom_range(0, 19) == 0) ? 16'($urandom) : src_en_i | 16'(1 << $urandom_range(0, 15));
      glob_en_i = $urandom_range(0, 29) != 0;
      if ($urandom_range(0, 49) == 0) set_lvl($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 3));
      if ($urandom_range(0, 9) == 0) cpu_lvl_i = 4'($urandom_range(0, 10));
      lock_start_i = $urandom_range(0, 39) == 0;
      lock_len_i = 2'($urandom_range(0, 3));
      retire_i = $urandom_range(0, 2) == 0;
      svc_ready_i = $urandom_range(0, 2) != 0;
      tick();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion at %0t", $time);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule